// File: doc/BRIEF.md
# Serial Controller Host Register File

This block is the processor-facing register bank of a classic asynchronous serial controller. A host reaches eight byte-wide locations through a 3-bit offset, a write strobe and a read strobe. The block keeps the line, modem and interrupt-enable settings, a scratch byte and a 16-bit baud divisor. It assembles the status and interrupt-identification bytes from the state of the transmit holding register, the receive buffer and a modem status input, and drives one interrupt line.

The bit-level shift engines sit outside. A transmit serializer sees the holding byte and its valid flag and pulses `txTake` when it copies the byte. A receive deserializer pulses `rxValid` with a finished byte. A free-running counter, reloaded on every divisor write, emits a one-cycle tick at sixteen times the bit rate. One bit of the line control register swaps the divisor bytes in for the data and interrupt-enable locations. Read data is combinational on the offset. Side effects of a read, such as clearing a flag, take effect at the clock edge that ends the read cycle.

Top module: `serial_host_regs`

## Requirements
- R1: After reset the interrupt-enable, line-control and modem-control registers and both divisor bytes read 0x00. With `txIdle` high the status byte reads 0x60, the identification byte reads 0x01, and `irq`, `txValid` and `baudTick` are low.
- R2: With line-control bit 7 clear, a write to offset 0 loads `txData` and raises `txValid`. A read of offset 0 returns the last received byte. Offset 1 is the interrupt-enable register: bits 3..0 are stored and bits 7..4 read as zero.
- R3: With line-control bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. These accesses leave the holding register and the interrupt-enable register untouched.
- R4: Offsets 3, 4 and 7 read back all eight written bits, and the first two also drive `lineCtrl` and `modemCtrl`. Writes to offsets 2, 5 and 6 change nothing.
- R5: `rxValid` sets status bit 0 (data ready). A read of offset 0 with line-control bit 7 clear clears it.
- R6: A byte that arrives while data ready is set, and is not read in that same cycle, sets status bit 1 (overrun). A read of the status byte at offset 5 clears it.
- R7: Status bit 5 is 1 when the holding register is empty. A write to it empties it no longer, and `txTake` empties it. Status bit 6 equals bit 5 AND `txIdle`. All other status bits read 0.
- R8: The identification byte at offset 2 has bits 7..3 zero. Bit 0 is 0 exactly when a source is pending, and `irq` is its inverse. Bits 2..1 name the highest-priority enabled source, from highest to lowest: 11 for overrun (enable bit 2), 10 for data ready (enable bit 0), 01 for holding-register-empty (enable bit 1), 00 for modem status, which is pending when `modemStatus[3:0]` is nonzero (enable bit 3).
- R9: The holding-register-empty source becomes pending on `txTake`. It is cleared by a read of offset 2 that reports it, or by a new write to the holding register.
- R10: With divisor D nonzero, `baudTick` is a one-cycle pulse every D cycles. The first pulse comes D cycles after the divisor write that loaded D, because each write to a divisor byte restarts the count.
- R11: A divisor of zero keeps `baudTick` low.
- R12: Offset 6 reads the `modemStatus` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe; side effects at the clock edge |
| rdData | output | 8 | Read data, combinational on `addr` |
| irq | output | 1 | Interrupt request, active high |
| txData | output | 8 | Holding byte for the serializer |
| txValid | output | 1 | Holding register full |
| txTake | input | 1 | Serializer copied the holding byte |
| txIdle | input | 1 | Serializer has nothing shifting |
| rxData | input | 8 | Byte from the deserializer |
| rxValid | input | 1 | `rxData` is a new byte |
| modemStatus | input | 8 | Modem status byte, low nibble are change flags |
| lineCtrl | output | 8 | Line control setting |
| modemCtrl | output | 8 | Modem control setting |
| baudTick | output | 1 | Pulse at sixteen times the bit rate |

## Verification
The bench writes every byte value to the scratch, modem-control and interrupt-enable registers, and every value with bit 7 clear to the line-control register. This separates full-width storage from masked storage. The interrupt logic is tried with all 16 combinations of pending conditions against all 16 enable masks. This exposes any wrong priority order, missed gate or stale clear, and each case where the empty-holding source is reported is followed by a second read that shows the clear. Divisors from 1 to 24, one that uses the high byte, and zero are each timed for the first pulse and the following interval. This tells reload errors apart from off-by-one period errors.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef struct packed {
    logic wrThr;
    logic wrIer;
    logic wrLcr;
    logic wrMcr;
    logic wrScr;
    logic wrDivLo;
    logic wrDivHi;
    logic rdRbr;
    logic rdIir;
    logic rdLsr;
  } regStrobe_t;

  typedef enum logic [3:0] {
    SEL_RBR, SEL_IER, SEL_IIR, SEL_LCR, SEL_MCR,
    SEL_LSR, SEL_MSR, SEL_SCR, SEL_DIVLO, SEL_DIVHI
  } readSel_t;

  localparam logic [1:0] ID_LINE  = 2'b11;
  localparam logic [1:0] ID_RXRDY = 2'b10;
  localparam logic [1:0] ID_THRE  = 2'b01;
  localparam logic [1:0] ID_MODEM = 2'b00;

  localparam int IER_BITS  = 4;
  localparam int DLAB_BIT  = 7;

endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import sr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              dlab,
  output regStrobe_t        stb,
  output readSel_t          readSel
);

  always_comb begin
    stb     = '0;
    readSel = SEL_RBR;
    unique case (addr)
      3'd0: begin
        if (dlab) begin
          stb.wrDivLo = wrEn;
          readSel     = SEL_DIVLO;
        end else begin
          stb.wrThr   = wrEn;
          stb.rdRbr   = rdEn;
          readSel     = SEL_RBR;
        end
      end
      3'd1: begin
        if (dlab) begin
          stb.wrDivHi = wrEn;
          readSel     = SEL_DIVHI;
        end else begin
          stb.wrIer   = wrEn;
          readSel     = SEL_IER;
        end
      end
      3'd2: begin
        stb.rdIir = rdEn;
        readSel   = SEL_IIR;
      end
      3'd3: begin
        stb.wrLcr = wrEn;
        readSel   = SEL_LCR;
      end
      3'd4: begin
        stb.wrMcr = wrEn;
        readSel   = SEL_MCR;
      end
      3'd5: begin
        stb.rdLsr = rdEn;
        readSel   = SEL_LSR;
      end
      3'd6: readSel = SEL_MSR;
      default: begin
        stb.wrScr = wrEn;
        readSel   = SEL_SCR;
      end
    endcase
  end

endmodule

// File: rtl/sr_baud.sv
module sr_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             reload,
  output logic             tick
);

  logic [DIV_W-1:0] count;
  logic [DIV_W-1:0] lastCount;

  assign lastCount = divisor - DIV_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (reload || divisor == '0) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (count == lastCount) begin
      count <= '0;
      tick  <= 1'b1;
    end else begin
      count <= count + DIV_W'(1);
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/sr_datapath.sv
module sr_datapath
  import sr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  readSel_t          readSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txTake,
  input  logic              txIdle,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] modemStatus,
  output logic [DATA_W-1:0] lineCtrl,
  output logic [DATA_W-1:0] modemCtrl,
  output logic [DIV_W-1:0]  divisor,
  output logic              divReload
);

  logic [IER_BITS-1:0] intEnable;
  logic [DATA_W-1:0]   scratch;
  logic [DATA_W-1:0]   rxBuf;
  logic                dataReady;
  logic                overrun;
  logic                threPend;
  logic                anyPend;
  logic [1:0]          intId;
  logic [DATA_W-1:0]   iirByte;
  logic [DATA_W-1:0]   lsrByte;
  logic                thrEmpty;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnable <= '0;
      lineCtrl  <= '0;
      modemCtrl <= '0;
      scratch   <= '0;
      divisor   <= '0;
    end else begin
      if (stb.wrIer)   intEnable <= wrData[IER_BITS-1:0];
      if (stb.wrLcr)   lineCtrl  <= wrData;
      if (stb.wrMcr)   modemCtrl <= wrData;
      if (stb.wrScr)   scratch   <= wrData;
      if (stb.wrDivLo) divisor[DATA_W-1:0]     <= wrData;
      if (stb.wrDivHi) divisor[DIV_W-1:DATA_W] <= wrData;
    end
  end

  assign divReload = stb.wrDivLo | stb.wrDivHi;

  // transmit holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData   <= '0;
      txValid  <= 1'b0;
      threPend <= 1'b0;
    end else begin
      if (stb.wrThr) begin
        txData   <= wrData;
        txValid  <= 1'b1;
        threPend <= 1'b0;
      end else begin
        if (txTake) begin
          txValid  <= 1'b0;
          threPend <= 1'b1;
        end else if (stb.rdIir && anyPend && intId == ID_THRE) begin
          threPend <= 1'b0;
        end
      end
    end
  end

  // receive buffer and line errors
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf     <= '0;
      dataReady <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (rxValid) begin
        rxBuf     <= rxData;
        dataReady <= 1'b1;
      end else if (stb.rdRbr) begin
        dataReady <= 1'b0;
      end
      if (rxValid && dataReady && !stb.rdRbr) overrun <= 1'b1;
      else if (stb.rdLsr)                     overrun <= 1'b0;
    end
  end

  // interrupt priority
  always_comb begin
    anyPend = 1'b1;
    intId   = ID_MODEM;
    if (intEnable[2] && overrun)                 intId = ID_LINE;
    else if (intEnable[0] && dataReady)          intId = ID_RXRDY;
    else if (intEnable[1] && threPend)           intId = ID_THRE;
    else if (intEnable[3] && |modemStatus[3:0])  intId = ID_MODEM;
    else                                         anyPend = 1'b0;
  end

  assign irq      = anyPend;
  assign iirByte  = {{(DATA_W-3){1'b0}}, intId, ~anyPend};
  assign thrEmpty = ~txValid;
  assign lsrByte  = {1'b0, thrEmpty & txIdle, thrEmpty, 3'b000, overrun, dataReady};

  always_comb begin
    unique case (readSel)
      SEL_RBR:   rdData = rxBuf;
      SEL_IER:   rdData = {{(DATA_W-IER_BITS){1'b0}}, intEnable};
      SEL_IIR:   rdData = iirByte;
      SEL_LCR:   rdData = lineCtrl;
      SEL_MCR:   rdData = modemCtrl;
      SEL_LSR:   rdData = lsrByte;
      SEL_MSR:   rdData = modemStatus;
      SEL_SCR:   rdData = scratch;
      SEL_DIVLO: rdData = divisor[DATA_W-1:0];
      SEL_DIVHI: rdData = divisor[DIV_W-1:DATA_W];
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/serial_host_regs.sv
module serial_host_regs
  import sr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic [DATA_W-1:0] txData,
  output logic              txValid,
  input  logic              txTake,
  input  logic              txIdle,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] modemStatus,
  output logic [DATA_W-1:0] lineCtrl,
  output logic [DATA_W-1:0] modemCtrl,
  output logic              baudTick
);

  regStrobe_t       stb;
  readSel_t         readSel;
  logic [DIV_W-1:0] divisor;
  logic             divReload;

  sr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr    (addr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .dlab    (lineCtrl[DLAB_BIT]),
    .stb     (stb),
    .readSel (readSel)
  );

  sr_datapath #(.DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .readSel     (readSel),
    .wrData      (wrData),
    .rdData      (rdData),
    .irq         (irq),
    .txData      (txData),
    .txValid     (txValid),
    .txTake      (txTake),
    .txIdle      (txIdle),
    .rxData      (rxData),
    .rxValid     (rxValid),
    .modemStatus (modemStatus),
    .lineCtrl    (lineCtrl),
    .modemCtrl   (modemCtrl),
    .divisor     (divisor),
    .divReload   (divReload)
  );

  sr_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rstN    (rstN),
    .divisor (divisor),
    .reload  (divReload),
    .tick    (baudTick)
  );

endmodule

// File: rtl/serial_host_regs_chk.sv
module serial_host_regs_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       addr,
  input logic             wrEn,
  input logic [7:0]       wrData,
  input logic [7:0]       rdData,
  input logic             irq,
  input logic [7:0]       txData,
  input logic             txValid,
  input logic             txTake,
  input logic [7:0]       lineCtrl,
  input logic             baudTick,
  input logic [DIV_W-1:0] divisor
);

  logic thrWrite;
  assign thrWrite = wrEn && addr == 3'd0 && !lineCtrl[7];

  assert_ier_reserved_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd1 && !lineCtrl[7]) |-> rdData[7:4] == 4'h0);

  assert_thr_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> (txValid && txData == $past(wrData)));

  assert_take_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txTake && !thrWrite) |=> !txValid);

  assert_lsr_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    addr == 3'd5 |-> rdData[5] == !txValid);

  assert_irq_matches_iir_R8: assert property (@(posedge clk) disable iff (!rstN)
    addr == 3'd2 |-> (rdData[0] != irq && rdData[7:3] == 5'h0));

  assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    (baudTick && divisor > DIV_W'(1)) |=> !baudTick);

  assert_zero_div_silent_R11: assert property (@(posedge clk) disable iff (!rstN)
    divisor == '0 |=> !baudTick);

endmodule

bind serial_host_regs serial_host_regs_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdData   (rdData),
  .irq      (irq),
  .txData   (txData),
  .txValid  (txValid),
  .txTake   (txTake),
  .lineCtrl (lineCtrl),
  .baudTick (baudTick),
  .divisor  (divisor)
);

// File: tb/serial_host_regs_tb.sv
`timescale 1ns/100ps
module serial_host_regs_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       irq;
  logic [7:0] txData;
  logic       txValid;
  logic       txTake = 1'b0;
  logic       txIdle = 1'b1;
  logic [7:0] rxData = '0;
  logic       rxValid = 1'b0;
  logic [7:0] modemStatus = '0;
  logic [7:0] lineCtrl;
  logic [7:0] modemCtrl;
  logic       baudTick;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;
  logic lastIrq;

  always #2.5 clk = ~clk;

  serial_host_regs u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .irq(irq), .txData(txData),
    .txValid(txValid), .txTake(txTake), .txIdle(txIdle), .rxData(rxData),
    .rxValid(rxValid), .modemStatus(modemStatus), .lineCtrl(lineCtrl),
    .modemCtrl(modemCtrl), .baudTick(baudTick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData; lastIrq = irq;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rxByte(input logic [7:0] v);
    @(negedge clk);
    rxData = v; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic takePulse();
    @(negedge clk);
    txTake = 1'b1;
    @(negedge clk);
    txTake = 1'b0;
  endtask

  function automatic logic [7:0] expIir(input logic [3:0] ier, input bit ovr,
                                        input bit dr, input bit pend, input bit m);
    if (ovr && ier[2])       return 8'h06;
    else if (dr && ier[0])   return 8'h04;
    else if (pend && ier[1]) return 8'h02;
    else if (m && ier[3])    return 8'h00;
    else                     return 8'h01;
  endfunction

  task automatic timeDivisor(input int d);
    int c;
    wr(3'd1, 8'(d >> 8));
    wr(3'd0, 8'(d));
    c = 0;
    do begin @(negedge clk); c++; end while (!baudTick && c < 400);
    check("R10 first tick delay", c, d);
    c = 0;
    do begin @(negedge clk); c++; end while (!baudTick && c < 400);
    check("R10 tick interval", c, d);
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 txValid", txValid, 0);
    check("R1 baudTick", baudTick, 0);
    rd(3'd1, v); check("R1 ier", v, 8'h00);
    rd(3'd3, v); check("R1 lcr", v, 8'h00);
    rd(3'd4, v); check("R1 mcr", v, 8'h00);
    rd(3'd5, v); check("R1 lsr", v, 8'h60);
    rd(3'd2, v); check("R1 iir", v, 8'h01);
    wr(3'd3, 8'h80);
    rd(3'd0, v); check("R1 div lo", v, 8'h00);
    rd(3'd1, v); check("R1 div hi", v, 8'h00);
    wr(3'd3, 8'h00);

    // R4 full-width registers
    for (int i = 0; i < 256; i++) begin
      wr(3'd7, 8'(i)); rd(3'd7, v); check("R4 scratch", v, i);
      wr(3'd4, 8'(i)); rd(3'd4, v); check("R4 mcr", v, i);
      check("R4 modemCtrl port", modemCtrl, i);
    end
    for (int i = 0; i < 128; i++) begin
      wr(3'd3, 8'(i)); rd(3'd3, v); check("R4 lcr", v, i);
      check("R4 lineCtrl port", lineCtrl, i);
    end
    wr(3'd3, 8'h00);

    // R2 interrupt enable masking
    for (int i = 0; i < 256; i++) begin
      wr(3'd1, 8'(i)); rd(3'd1, v); check("R2 ier mask", v, i & 15);
    end
    wr(3'd1, 8'h00);

    // R3 divisor bank
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    rd(3'd0, v); check("R3 div lo", v, 8'h34);
    rd(3'd1, v); check("R3 div hi", v, 8'h12);
    check("R3 no tx load", txValid, 0);
    wr(3'd3, 8'h00);
    rd(3'd1, v); check("R3 ier untouched", v, 8'h00);

    // R2 / R7 holding register
    wr(3'd0, 8'hA5);
    check("R2 txData", txData, 8'hA5);
    check("R2 txValid", txValid, 1);
    rd(3'd5, v); check("R7 lsr full", v, 8'h00);
    takePulse();
    check("R7 txValid after take", txValid, 0);
    rd(3'd5, v); check("R7 lsr empty idle", v, 8'h60);
    txIdle = 1'b0;
    rd(3'd5, v); check("R7 lsr empty busy", v, 8'h20);
    txIdle = 1'b1;

    // R4 ignored writes
    wr(3'd5, 8'hFF); rd(3'd5, v); check("R4 lsr write ignored", v, 8'h60);
    wr(3'd6, 8'hFF); wr(3'd2, 8'hFF);
    rd(3'd2, v); check("R4 iir write ignored", v, 8'h01);

    // R12 modem status
    modemStatus = 8'hB4;
    rd(3'd6, v); check("R12 msr", v, 8'hB4);
    modemStatus = 8'h00;

    // R5 / R6 receive path
    rxByte(8'h5A);
    rd(3'd5, v); check("R5 data ready", v, 8'h61);
    rd(3'd0, v); check("R2 rbr", v, 8'h5A);
    rd(3'd5, v); check("R5 ready cleared", v, 8'h60);
    rxByte(8'h11);
    rxByte(8'h22);
    rd(3'd5, v); check("R6 overrun", v, 8'h63);
    rd(3'd5, v); check("R6 overrun cleared", v, 8'h61);
    rd(3'd0, v); check("R6 newest byte kept", v, 8'h22);

    // R8 / R9 priority sweep
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        bit ovr, dr, pend, m;
        logic [7:0 ] exp;
        ovr = s[0]; dr = s[0] | s[1]; pend = s[2]; m = s[3];
        wr(3'd1, 8'h00);
        rd(3'd5, v); rd(3'd0, v);
        wr(3'd0, 8'h00);
        if (s[0]) begin rxByte(8'h01); rxByte(8'h02); end
        else if (s[1]) rxByte(8'h03);
        if (pend) takePulse();
        modemStatus = m ? 8'h01 : 8'h00;
        wr(3'd1, 8'(e));
        exp = expIir(4'(e), ovr, dr, pend, m);
        rd(3'd2, v);
        check("R8 iir", v, exp);
        check("R8 irq", lastIrq, exp[0] ? 0 : 1);
        if (exp == 8'h02) begin
          rd(3'd2, v);
          check("R9 thre cleared by iir read", v, expIir(4'(e), ovr, dr, 1'b0, m));
        end
      end
    end
    modemStatus = 8'h00;

    // R9 cleared by holding write
    wr(3'd1, 8'h00); rd(3'd5, v); rd(3'd0, v);
    wr(3'd0, 8'h00); takePulse();
    wr(3'd1, 8'h02);
    @(negedge clk); check("R9 irq on empty", irq, 1);
    wr(3'd0, 8'h77);
    check("R9 irq cleared by write", irq, 0);
    takePulse();
    wr(3'd1, 8'h00);

    // R10 / R11 baud tick
    wr(3'd3, 8'h80);
    for (int d = 1; d <= 24; d++) timeDivisor(d);
    timeDivisor(256);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    begin
      int seen = 0;
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (baudTick) seen++; end
      check("R11 zero divisor silent", seen, 0);
    end
    wr(3'd3, 8'h00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule